// File: doc/BRIEF.md
# CPU-Side Bank Register Decoder

This block is the processor-facing half of a cartridge memory mapper. It watches processor writes in the upper 32 KB of the address space and turns them into one program-bank register, four character-bank registers and a nametable mirroring bit. It also translates every processor address in that upper half into an address for the program ROM. The window is split into four 8 KB slots. Only the lowest slot can be switched. The three slots above it are pinned to the last three banks of the ROM, and the bank count comes in on a port.

The four character-bank values go out unchanged to a separate latch block. That block chooses between them during pattern fetches. Processor addresses below the ROM window produce no ROM access. The read-enable output falls so that the bus keeps its open-bus value there. The ROM array itself sits outside this block.

Top module: `prg_bank_decoder`

## Requirements
- R1: A processor address in $8000-$9FFF gives a ROM address of {program bank register, cpu_addr[12:0]}.
- R2: Addresses in $A000-$BFFF, $C000-$DFFF and $E000-$FFFF use banks (rom_banks_i - 3), (rom_banks_i - 2) and (rom_banks_i - 1), truncated to the bank width and followed by cpu_addr[12:0]. They follow a change of rom_banks_i in the same cycle.
- R3: A strobed write anywhere in $A000-$AFFF loads the program bank register with data bits [3:0] and discards the upper data bits. The new bank is used from the next cycle on. The translated address in the write cycle still comes from the old state.
- R4: Strobed writes in $B000-$BFFF, $C000-$CFFF, $D000-$DFFF and $E000-$EFFF load chr_lo_a_o, chr_lo_b_o, chr_hi_a_o and chr_hi_b_o respectively. Each keeps data bits [4:0].
- R5: A strobed write in $F000-$FFFF sets mirror_horiz_o to data bit 0, where 0 means vertical and 1 means horizontal.
- R6: While rst_ni is low, the program bank register, all four character-bank outputs and mirror_horiz_o are 0, so bank 0 appears at $8000.
- R7: prg_rd_en_o is 1 exactly when cpu_addr_i is at $8000 or above. When it is 0, prg_addr_o is 0.
- R8: Strobed writes to $0000-$9FFF, which includes $6000-$7FFF and $8000-$9FFF, change no register.
- R9: With cpu_we_i low, no register changes whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | Processor address |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_we_i | input | 1 | Write strobe, sampled on the rising edge |
| rom_banks_i | input | 5 | Program ROM size in 8 KB banks |
| prg_addr_o | output | 17 | Program ROM byte address |
| prg_rd_en_o | output | 1 | ROM drives the bus; 0 means open bus |
| mirror_horiz_o | output | 1 | 0 vertical, 1 horizontal mirroring |
| chr_lo_a_o | output | 5 | Low 4 KB region bank, latch state A |
| chr_lo_b_o | output | 5 | Low 4 KB region bank, latch state B |
| chr_hi_a_o | output | 5 | High 4 KB region bank, latch state A |
| chr_hi_b_o | output | 5 | High 4 KB region bank, latch state B |

## Verification
A write and an address translation always share a cycle, because one address bus carries both. A strobed write to $A000 or $F000 is therefore also a lookup in a fixed slot. The bench drives such writes and checks that the translated address in that cycle comes from the fixed slot and the old state. It then reads $8000 or watches the mirroring output on the following cycle and checks that the new value appears there and not earlier. Ignored writes to $6000 and $8000-$9FFF are judged the same way: the next reads at $8000 must show the unchanged bank.

// File: rtl/prg_dec_pkg.sv
package prg_dec_pkg;
  typedef enum logic [2:0] {
    WT_NONE,
    WT_PRG,
    WT_CHR_LO_A,
    WT_CHR_LO_B,
    WT_CHR_HI_A,
    WT_CHR_HI_B,
    WT_MIRROR
  } wr_tgt_e;
endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
  import prg_dec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output wr_tgt_e           tgt_o
);
  logic unused_lo;
  assign unused_lo = ^addr_i[ADDR_W-5:0];

  // 4 KB register windows, upper half only
  always_comb begin
    tgt_o = WT_NONE;
    if (we_i && addr_i[ADDR_W-1]) begin
      unique case (addr_i[ADDR_W-2:ADDR_W-4])
        3'b010:  tgt_o = WT_PRG;
        3'b011:  tgt_o = WT_CHR_LO_A;
        3'b100:  tgt_o = WT_CHR_LO_B;
        3'b101:  tgt_o = WT_CHR_HI_A;
        3'b110:  tgt_o = WT_CHR_HI_B;
        3'b111:  tgt_o = WT_MIRROR;
        default: tgt_o = WT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_dec_pkg::*;
#(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_REG_W  = 5,
  parameter int DATA_W     = 8,
  parameter int N_CHR      = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  wr_tgt_e               tgt_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [PRG_BANK_W-1:0] prg_bank_o,
  output logic [CHR_REG_W-1:0]  chr_o [N_CHR],
  output logic                  mirror_o
);
  logic unused_data;
  assign unused_data = ^wdata_i[DATA_W-1:CHR_REG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prg_bank_o <= '0;
      mirror_o   <= 1'b0;
    end else begin
      if (tgt_i == WT_PRG)    prg_bank_o <= wdata_i[PRG_BANK_W-1:0];
      if (tgt_i == WT_MIRROR) mirror_o   <= wdata_i[0];
    end
  end

  for (genvar i = 0; i < N_CHR; i++) begin : g_chr
    localparam wr_tgt_e MY_TGT = wr_tgt_e'(int'(WT_CHR_LO_A) + i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              chr_o[i] <= '0;
      else if (tgt_i == MY_TGT) chr_o[i] <= wdata_i[CHR_REG_W-1:0];
    end

    assert_chr_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tgt_i == MY_TGT) |=> (chr_o[i] == $past(wdata_i[CHR_REG_W-1:0])));

    assert_chr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tgt_i != MY_TGT) |=> $stable(chr_o[i]));
  end

  assert_prg_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prg_bank_o) |-> ($past(tgt_i) == WT_PRG));

  assert_prg_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_i == WT_PRG) |=> (prg_bank_o == $past(wdata_i[PRG_BANK_W-1:0])));

  assert_mirror_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_i == WT_MIRROR) |=> (mirror_o == $past(wdata_i[0])));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_i == WT_NONE) |=> ($stable(prg_bank_o) && $stable(mirror_o)));
endmodule

// File: rtl/prg_addr_map.sv
module prg_addr_map #(
  parameter int ADDR_W     = 16,
  parameter int PRG_BANK_W = 4,
  parameter int OFFS_W     = 13,
  parameter int CNT_W      = PRG_BANK_W + 1
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [PRG_BANK_W-1:0]        prg_bank_i,
  input  logic [CNT_W-1:0]             rom_banks_i,
  output logic [PRG_BANK_W+OFFS_W-1:0] prg_addr_o,
  output logic                         rd_en_o
);
  logic [1:0]            slot;
  logic [2:0]            back;
  logic [CNT_W-1:0]      fixed_full;
  logic [PRG_BANK_W-1:0] bank;
  logic                  unused_hi;

  assign slot       = addr_i[OFFS_W+1:OFFS_W];
  // slot 1..3 -> last-3, last-2, last-1
  assign back       = 3'd4 - {1'b0, slot};
  assign fixed_full = rom_banks_i - CNT_W'(back);
  assign unused_hi  = fixed_full[CNT_W-1];
  assign bank       = (slot == 2'd0) ? prg_bank_i : fixed_full[PRG_BANK_W-1:0];
  assign rd_en_o    = addr_i[ADDR_W-1];
  assign prg_addr_o = rd_en_o ? {bank, addr_i[OFFS_W-1:0]} : '0;
endmodule

// File: rtl/prg_bank_decoder.sv
module prg_bank_decoder
  import prg_dec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PRG_BANK_W = 4,
  parameter int CHR_REG_W  = 5,
  localparam int OFFS_W     = 13,
  localparam int CNT_W      = PRG_BANK_W + 1,
  localparam int PRG_ADDR_W = PRG_BANK_W + OFFS_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     cpu_addr_i,
  input  logic [DATA_W-1:0]     cpu_wdata_i,
  input  logic                  cpu_we_i,
  input  logic [CNT_W-1:0]      rom_banks_i,
  output logic [PRG_ADDR_W-1:0] prg_addr_o,
  output logic                  prg_rd_en_o,
  output logic                  mirror_horiz_o,
  output logic [CHR_REG_W-1:0]  chr_lo_a_o,
  output logic [CHR_REG_W-1:0]  chr_lo_b_o,
  output logic [CHR_REG_W-1:0]  chr_hi_a_o,
  output logic [CHR_REG_W-1:0]  chr_hi_b_o
);
  localparam int N_CHR = 4;

  wr_tgt_e               wr_tgt;
  logic [PRG_BANK_W-1:0] prg_bank;
  logic [CHR_REG_W-1:0]  chr_q [N_CHR];

  prg_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (cpu_addr_i),
    .we_i   (cpu_we_i),
    .tgt_o  (wr_tgt)
  );

  prg_bank_regs #(
    .PRG_BANK_W (PRG_BANK_W),
    .CHR_REG_W  (CHR_REG_W),
    .DATA_W     (DATA_W),
    .N_CHR      (N_CHR)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tgt_i      (wr_tgt),
    .wdata_i    (cpu_wdata_i),
    .prg_bank_o (prg_bank),
    .chr_o      (chr_q),
    .mirror_o   (mirror_horiz_o)
  );

  prg_addr_map #(
    .ADDR_W     (ADDR_W),
    .PRG_BANK_W (PRG_BANK_W),
    .OFFS_W     (OFFS_W),
    .CNT_W      (CNT_W)
  ) u_map (
    .addr_i      (cpu_addr_i),
    .prg_bank_i  (prg_bank),
    .rom_banks_i (rom_banks_i),
    .prg_addr_o  (prg_addr_o),
    .rd_en_o     (prg_rd_en_o)
  );

  assign chr_lo_a_o = chr_q[0];
  assign chr_lo_b_o = chr_q[1];
  assign chr_hi_a_o = chr_q[2];
  assign chr_hi_b_o = chr_q[3];

  assert_open_bus_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_addr_i[ADDR_W-1] |-> (!prg_rd_en_o && (prg_addr_o == '0)));

  assert_slot0_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[ADDR_W-1:OFFS_W] == 3'b100) |->
      (prg_addr_o == {prg_bank, cpu_addr_i[OFFS_W-1:0]}));

  assert_last_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[ADDR_W-1:OFFS_W] == 3'b111) |->
      (prg_addr_o[PRG_ADDR_W-1:OFFS_W] == PRG_BANK_W'(rom_banks_i - CNT_W'(1))));

  assert_low_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && (cpu_addr_i[ADDR_W-1:ADDR_W-3] < 3'b101)) |=> $stable(prg_bank));
endmodule

// File: tb/prg_bank_decoder_tb.sv
module prg_bank_decoder_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h8000;
  logic [7:0]  wdata = 8'h00;
  logic        we = 1'b0;
  logic [4:0]  banks = 5'd8;
  logic [16:0] prg_addr;
  logic        rd_en, mir;
  logic [4:0]  c_la, c_lb, c_ha, c_hb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  prg_bank_decoder u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .cpu_addr_i     (addr),
    .cpu_wdata_i    (wdata),
    .cpu_we_i       (we),
    .rom_banks_i    (banks),
    .prg_addr_o     (prg_addr),
    .prg_rd_en_o    (rd_en),
    .mirror_horiz_o (mir),
    .chr_lo_a_o     (c_la),
    .chr_lo_b_o     (c_lb),
    .chr_hi_a_o     (c_ha),
    .chr_hi_b_o     (c_hb)
  );

  // {we, addr, data, exp_addr, exp_rd, exp_mir, exp chr la,lb,ha,hb}; expected = state before this row's write, banks=8
  localparam logic [63:0] VECS [NV] = '{
    {1'b0, 16'h8000, 8'h00, 17'h00000, 1'b1, 1'b0, 5'h00, 5'h00, 5'h00, 5'h00}, // R1
    {1'b0, 16'hA123, 8'h00, 17'h0A123, 1'b1, 1'b0, 5'h00, 5'h00, 5'h00, 5'h00}, // R2
    {1'b0, 16'hC456, 8'h00, 17'h0C456, 1'b1, 1'b0, 5'h00, 5'h00, 5'h00, 5'h00}, // R2
    {1'b0, 16'hFFFF, 8'h00, 17'h0FFFF, 1'b1, 1'b0, 5'h00, 5'h00, 5'h00, 5'h00}, // R2
    {1'b1, 16'hA000, 8'hF3, 17'h0A000, 1'b1, 1'b0, 5'h00, 5'h00, 5'h00, 5'h00}, // R3 write, old state
    {1'b0, 16'h9ABC, 8'h00, 17'h07ABC, 1'b1, 1'b0, 5'h00, 5'h00, 5'h00, 5'h00}, // R3 bank 3
    {1'b1, 16'hB7FF, 8'hE9, 17'h0B7FF, 1'b1, 1'b0, 5'h00, 5'h00, 5'h00, 5'h00}, // R4
    {1'b1, 16'hC000, 8'h3F, 17'h0C000, 1'b1, 1'b0, 5'h09, 5'h00, 5'h00, 5'h00}, // R4
    {1'b1, 16'hD001, 8'h12, 17'h0D001, 1'b1, 1'b0, 5'h09, 5'h1F, 5'h00, 5'h00}, // R4
    {1'b1, 16'hEFFF, 8'hA4, 17'h0EFFF, 1'b1, 1'b0, 5'h09, 5'h1F, 5'h12, 5'h00}, // R4
    {1'b1, 16'hF800, 8'h01, 17'h0F800, 1'b1, 1'b0, 5'h09, 5'h1F, 5'h12, 5'h04}, // R5
    {1'b1, 16'h6000, 8'hFF, 17'h00000, 1'b0, 1'b1, 5'h09, 5'h1F, 5'h12, 5'h04}, // R8 R7
    {1'b1, 16'h8000, 8'h07, 17'h06000, 1'b1, 1'b1, 5'h09, 5'h1F, 5'h12, 5'h04}, // R8
    {1'b1, 16'h9FFF, 8'h1F, 17'h07FFF, 1'b1, 1'b1, 5'h09, 5'h1F, 5'h12, 5'h04}, // R8
    {1'b0, 16'h5000, 8'h00, 17'h00000, 1'b0, 1'b1, 5'h09, 5'h1F, 5'h12, 5'h04}, // R7
    {1'b0, 16'hA000, 8'h0C, 17'h0A000, 1'b1, 1'b1, 5'h09, 5'h1F, 5'h12, 5'h04}, // R9
    {1'b0, 16'h8000, 8'h00, 17'h06000, 1'b1, 1'b1, 5'h09, 5'h1F, 5'h12, 5'h04}, // R9
    {1'b1, 16'hF000, 8'hFE, 17'h0F000, 1'b1, 1'b1, 5'h09, 5'h1F, 5'h12, 5'h04}, // R5
    {1'b0, 16'h8000, 8'h00, 17'h06000, 1'b1, 1'b0, 5'h09, 5'h1F, 5'h12, 5'h04}  // R5 R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R6 reset state
    #(CLK_P * 2 + 1);
    check("R6 prg_addr at 8000", 32'(prg_addr), 32'h0);
    check("R6 mirror", 32'(mir), 32'h0);
    check("R6 chr", 32'({c_la, c_lb, c_ha, c_hb}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      we    = VECS[i][63];
      addr  = VECS[i][62:47];
      wdata = VECS[i][46:39];
      #1;
      check($sformatf("R1/R2/R3 addr row %0d", i), 32'(prg_addr), 32'(VECS[i][38:22]));
      check($sformatf("R7 rd_en row %0d", i), 32'(rd_en), 32'(VECS[i][21]));
      check($sformatf("R5 mirror row %0d", i), 32'(mir), 32'(VECS[i][20]));
      check($sformatf("R4/R8 chr row %0d", i), 32'({c_la, c_lb, c_ha, c_hb}), 32'(VECS[i][19:0]));
    end
    @(negedge clk);
    we = 1'b0;

    // R2 other ROM sizes, combinational follow
    banks = 5'd16;
    addr  = 16'hE000;
    #1 check("R2 last slot, 16 banks", 32'(prg_addr), 32'h1E000);
    addr = 16'hA000;
    #1 check("R2 third-to-last, 16 banks", 32'(prg_addr), 32'h1A000);
    banks = 5'd4;
    addr  = 16'hC000;
    #1 check("R2 second-to-last, 4 banks", 32'(prg_addr), 32'h04000);
    addr = 16'h8001;
    #1 check("R1 slot0 unaffected by size", 32'(prg_addr), 32'h06001);

    // R3 upper data bits discarded
    @(negedge clk);
    we    = 1'b1;
    addr  = 16'hAFFF;
    wdata = 8'hB2;
    @(negedge clk);
    we   = 1'b0;
    addr = 16'h8000;
    #1 check("R3 mask to bank 2", 32'(prg_addr), 32'h04000);

    // R6 mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R6 reset prg bank", 32'(prg_addr), 32'h0);
    check("R6 reset chr", 32'({c_la, c_lb, c_ha, c_hb}), 32'h0);
    check("R6 reset mirror", 32'(mir), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule